// File: doc/BRIEF.md
# Manual Serial Pin Sequencer

This block drives the chip-select, clock and data pins of a serial link to a slave device one micro-operation at a time. It is used during bring-up and to put the slave into a known state before an automatic transfer engine takes over. Each command raises or lowers chip select, gives a single clock pulse, or shifts out one byte over one, two or four data lines.

The pins are handed to the sequencer only while both the manual-enable input and the pin-routing select are high. Otherwise the pins carry the automatic engine's signals unchanged. Accepted commands wait in a small queue. A busy output stays high from the cycle after a command is accepted until the queue is empty and the last operation has finished.

Top module: `man_pin_seq`

## Requirements
- R1: After reset, with manual control selected, `csN` is 1, `sclk` is 0, `sdo` is 0 and `busy` is 0.
- R2: While `manEn` or `muxSel` is low, `csN`, `sclk` and `sdo` equal `autoCsN`, `autoSclk` and `autoSdo`.
- R3: A command is accepted only when `cmdValid`, `manEn`, `muxSel` and the write flag `cmdData[13]` are all high. Any other write leaves `busy` low and produces no clock edge.
- R4: Opcode `cmdData[11:8]`=1 drives `csN` low and opcode 0 drives it high. Neither opcode produces a clock pulse.
- R5: Opcode 2 produces exactly one `sclk` pulse with `sdo` at 0.
- R6: Opcode 8 sends `cmdData[7:0]` MSB first on `sdo[0]`, one bit per rising edge of `sclk`, for 8 rising edges. `sdo[3:1]` stays 0 during this transfer.
- R7: Opcode 9 sends the byte in 4 rising edges, two bits per edge, with the more significant bit of each pair on `sdo[1]`.
- R8: Opcode 0xA sends the byte in 2 rising edges, high nibble first, with the nibble on `sdo[3:0]` and bit 3 of the nibble on `sdo[3]`.
- R9: `busy` is high in the cycle after a command is accepted. For an opcode 8 command written to an empty, idle block, `busy` stays high for 1+16*HALF_CYC cycles. `sclk` is 0 whenever manual control is selected and `busy` is low.
- R10: The queue holds FIFO_DEPTH (default 4) pending commands. A command written while the queue is full is discarded.
- R11: A write-flagged command whose opcode is not 0, 1, 2, 8, 9 or 0xA is discarded.
- R12: Each `sclk` pulse is high for HALF_CYC clock cycles. Consecutive rising edges within one transfer are 2*HALF_CYC cycles apart.
- R13: The slave reset sequence gives 40 rising clock edges. These are chip select low, one opcode 8 byte, chip select high, then four more opcode 8 bytes. Exactly 8 of the 40 edges occur while `csN` is low, and `csN` ends high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| manEn | input | 1 | Manual control enable |
| muxSel | input | 1 | Routes the pins to the sequencer when high |
| cmdValid | input | 1 | Command write strobe |
| cmdData | input | 16 | Command: bit 13 write flag, 11:8 opcode, 7:0 data |
| autoCsN | input | 1 | Chip select from the automatic engine |
| autoSclk | input | 1 | Clock from the automatic engine |
| autoSdo | input | 4 | Data lines from the automatic engine |
| busy | output | 1 | A command is queued or executing |
| csN | output | 1 | Chip select pin, active low |
| sclk | output | 1 | Serial clock pin |
| sdo | output | 4 | Serial data pins |

## Verification
A stuck control state or a wrong tick count shows up at the pins within one bit period (2*HALF_CYC cycles). It appears as a missing or extra `sclk` edge, a pulse width off by a cycle, or `busy` failing to fall. A wrong lane setting or shift distance corrupts the bits captured at the next rising edge. A queue pointer fault shows as a lost or repeated byte when a burst of commands is written while one is still executing.

// File: rtl/man_seq_pkg.sv
package man_seq_pkg;

  localparam int WRITE_BIT = 13;

  typedef enum logic [3:0] {
    OP_CS_HIGH = 4'h0,
    OP_CS_LOW  = 4'h1,
    OP_CLK     = 4'h2,
    OP_OUT1    = 4'h8,
    OP_OUT2    = 4'h9,
    OP_OUT4    = 4'hA
  } opcode_e;

  typedef enum logic [1:0] {
    LANE1 = 2'd0,
    LANE2 = 2'd1,
    LANE4 = 2'd2
  } lane_e;

  typedef struct packed {
    logic  load;
    lane_e lane;
    logic  zeroData;
    logic  shift;
    logic  sclkHi;
    logic  sclkLo;
    logic  csHi;
    logic  csLo;
  } dp_ctl_t;

  function automatic logic isKnownOp(input logic [3:0] op);
    case (op)
      OP_CS_HIGH, OP_CS_LOW, OP_CLK, OP_OUT1, OP_OUT2, OP_OUT4: isKnownOp = 1'b1;
      default: isKnownOp = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/man_seq_fifo.sv
module man_seq_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 12,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign rdData = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    nextPtr = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push && !full) wrPtr <= nextPtr(wrPtr);
      if (pop && !empty) rdPtr <= nextPtr(rdPtr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/man_seq_ctrl.sv
module man_seq_ctrl
  import man_seq_pkg::*;
#(
  parameter int HALF_CYC = 2,
  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       empty,
  input  logic [3:0] headOp,
  output logic       pop,
  output dp_ctl_t    ctl,
  output logic       busy
);

  typedef enum logic [1:0] {S_IDLE, S_CSHOLD, S_LOW, S_HIGH} state_e;

  state_e      state;
  logic [TW-1:0] tickCnt;
  logic [3:0]  clkLeft;
  logic        lastTick;

  assign lastTick = (tickCnt == TW'(HALF_CYC - 1));
  assign busy     = (state != S_IDLE) || !empty;

  always_comb begin
    ctl = '0;
    pop = 1'b0;
    case (state)
      S_IDLE: begin
        if (!empty) begin
          pop = 1'b1;
          case (headOp)
            OP_CS_HIGH: ctl.csHi = 1'b1;
            OP_CS_LOW:  ctl.csLo = 1'b1;
            OP_CLK:     begin ctl.load = 1'b1; ctl.zeroData = 1'b1; ctl.lane = LANE1; end
            OP_OUT2:    begin ctl.load = 1'b1; ctl.lane = LANE2; end
            OP_OUT4:    begin ctl.load = 1'b1; ctl.lane = LANE4; end
            default:    begin ctl.load = 1'b1; ctl.lane = LANE1; end
          endcase
        end
      end
      S_LOW:  if (lastTick) ctl.sclkHi = 1'b1;
      S_HIGH: if (lastTick) begin ctl.sclkLo = 1'b1; ctl.shift = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tickCnt <= '0;
      clkLeft <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          tickCnt <= '0;
          if (!empty) begin
            case (headOp)
              OP_CS_HIGH, OP_CS_LOW: state <= S_CSHOLD;
              default:               state <= S_LOW;
            endcase
            case (headOp)
              OP_CLK:  clkLeft <= 4'd1;
              OP_OUT2: clkLeft <= 4'd4;
              OP_OUT4: clkLeft <= 4'd2;
              default: clkLeft <= 4'd8;
            endcase
          end
        end
        S_CSHOLD: begin
          if (lastTick) begin
            state   <= S_IDLE;
            tickCnt <= '0;
          end else tickCnt <= tickCnt + 1'b1;
        end
        S_LOW: begin
          if (lastTick) begin
            state   <= S_HIGH;
            tickCnt <= '0;
          end else tickCnt <= tickCnt + 1'b1;
        end
        S_HIGH: begin
          if (lastTick) begin
            tickCnt <= '0;
            clkLeft <= clkLeft - 1'b1;
            state   <= (clkLeft == 4'd1) ? S_IDLE : S_LOW;
          end else tickCnt <= tickCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/man_seq_dp.sv
module man_seq_dp
  import man_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dp_ctl_t    ctl,
  input  logic [7:0] cmdByte,
  input  logic       manual,
  input  logic       autoCsN,
  input  logic       autoSclk,
  input  logic [3:0] autoSdo,
  output logic       csN,
  output logic       sclk,
  output logic [3:0] sdo
);

  logic [7:0] shiftReg;
  lane_e      lane;
  logic       csReg, sclkReg;
  logic [3:0] manSdo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      lane     <= LANE1;
      csReg    <= 1'b1;
      sclkReg  <= 1'b0;
    end else begin
      if (ctl.load) begin
        shiftReg <= ctl.zeroData ? 8'h00 : cmdByte;
        lane     <= ctl.lane;
      end else if (ctl.shift) begin
        case (lane)
          LANE2:   shiftReg <= {shiftReg[5:0], 2'b00};
          LANE4:   shiftReg <= {shiftReg[3:0], 4'b0000};
          default: shiftReg <= {shiftReg[6:0], 1'b0};
        endcase
      end
      if (ctl.sclkHi) sclkReg <= 1'b1;
      else if (ctl.sclkLo) sclkReg <= 1'b0;
      if (ctl.csLo) csReg <= 1'b0;
      else if (ctl.csHi) csReg <= 1'b1;
    end
  end

  always_comb begin
    case (lane)
      LANE2:   manSdo = {2'b00, shiftReg[7:6]};
      LANE4:   manSdo = shiftReg[7:4];
      default: manSdo = {3'b000, shiftReg[7]};
    endcase
  end

  assign csN  = manual ? csReg   : autoCsN;
  assign sclk = manual ? sclkReg : autoSclk;
  assign sdo  = manual ? manSdo  : autoSdo;

endmodule

// File: rtl/man_pin_seq.sv
module man_pin_seq
  import man_seq_pkg::*;
#(
  parameter int HALF_CYC   = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        manEn,
  input  logic        muxSel,
  input  logic        cmdValid,
  input  logic [15:0] cmdData,
  input  logic        autoCsN,
  input  logic        autoSclk,
  input  logic [3:0]  autoSdo,
  output logic        busy,
  output logic        csN,
  output logic        sclk,
  output logic [3:0]  sdo
);

  localparam int ENTRY_W = 12;
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

  logic               manual, accept;
  logic               fifoEmpty, fifoFull, pop;
  logic [ENTRY_W-1:0] head;
  logic [CNT_W-1:0]   fifoCount;
  dp_ctl_t            ctl;
  logic               unusedCmdBits;

  assign unusedCmdBits = ^{cmdData[15:14], cmdData[12]};
  assign manual = manEn && muxSel;
  assign accept = cmdValid && manual && cmdData[WRITE_BIT] && isKnownOp(cmdData[11:8]);

  man_seq_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) i_fifo (
    .clk(clk), .rstN(rstN), .push(accept), .wrData(cmdData[11:0]),
    .pop(pop), .rdData(head), .empty(fifoEmpty), .full(fifoFull), .count(fifoCount)
  );

  man_seq_ctrl #(.HALF_CYC(HALF_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .empty(fifoEmpty), .headOp(head[11:8]),
    .pop(pop), .ctl(ctl), .busy(busy)
  );

  man_seq_dp i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdByte(head[7:0]), .manual(manual),
    .autoCsN(autoCsN), .autoSclk(autoSclk), .autoSdo(autoSdo),
    .csN(csN), .sclk(sclk), .sdo(sdo)
  );

  logic unusedFull;
  assign unusedFull = fifoFull;

endmodule

// File: rtl/man_seq_chk.sv
module man_seq_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          manEn,
  input logic          muxSel,
  input logic          cmdValid,
  input logic [5:0]    cmdTag,
  input logic          busy,
  input logic          csN,
  input logic          sclk,
  input logic [CW-1:0] fifoCount
);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && manEn && muxSel && cmdTag == 6'b101000) |=> busy);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));

  // R9
  clk_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (manEn && muxSel && !busy) |-> !sclk);

  // R3
  sclk_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (manEn && muxSel && $past(manEn && muxSel) && $rose(sclk)) |-> $past(busy));

  // R4
  cs_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (manEn && muxSel && $past(manEn && muxSel) && !$stable(csN)) |-> $past(busy));

endmodule

bind man_pin_seq man_seq_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .manEn(manEn), .muxSel(muxSel), .cmdValid(cmdValid),
  .cmdTag(cmdData[13:8]), .busy(busy), .csN(csN), .sclk(sclk), .fifoCount(fifoCount)
);

// File: tb/test_man_pin_seq.sv
`timescale 1ns/1ps
module test_man_pin_seq;

  localparam int HALF = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic manEn = 1'b1, muxSel = 1'b1, cmdValid = 1'b0;
  logic [15:0] cmdData = '0;
  logic autoCsN = 1'b1, autoSclk = 1'b0;
  logic [3:0] autoSdo = '0;
  logic busy, csN, sclk;
  logic [3:0] sdo;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  man_pin_seq #(.HALF_CYC(HALF), .FIFO_DEPTH(4)) i_man_pin_seq (
    .clk(clk), .rstN(rstN), .manEn(manEn), .muxSel(muxSel), .cmdValid(cmdValid),
    .cmdData(cmdData), .autoCsN(autoCsN), .autoSclk(autoSclk), .autoSdo(autoSdo),
    .busy(busy), .csN(csN), .sclk(sclk), .sdo(sdo)
  );

  always #5 clk = ~clk;

  // pin monitor
  bit monOn = 0;
  int riseCnt = 0, riseCsLow = 0;
  logic [3:0] riseSdo [64];
  realtime lastRise = 0, hiTime = 0, period = 0;

  always @(posedge sclk) if (monOn) begin
    if (riseCnt < 64) riseSdo[riseCnt] = sdo;
    if (riseCnt > 0) period = $realtime - lastRise;
    if (!csN) riseCsLow++;
    riseCnt++;
    lastRise = $realtime;
  end
  always @(negedge sclk) if (monOn) hiTime = $realtime - lastRise;

  task automatic clearMon();
    riseCnt = 0; riseCsLow = 0; period = 0; hiTime = 0;
    monOn = 1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendCmd(input logic [15:0] c);
    @(negedge clk); cmdValid = 1'b1; cmdData = c;
    @(negedge clk); cmdValid = 1'b0; cmdData = '0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000; i++) begin
      if (!busy) return;
      @(negedge clk);
    end
    check(0, "busy timeout", busy, 0);
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(csN == 1'b1, "R1 csN", csN, 1);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    check(sdo == 4'h0, "R1 sdo", sdo, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
  endtask

  task automatic t_mux();
    monOn = 0;
    @(negedge clk); manEn = 1'b0; autoCsN = 1'b0; autoSclk = 1'b1; autoSdo = 4'hA;
    #1;
    check({csN, sclk, sdo} == {1'b0, 1'b1, 4'hA}, "R2 manEn low", {csN, sclk, sdo}, 6'h1A);
    manEn = 1'b1; muxSel = 1'b0; autoCsN = 1'b1; autoSclk = 1'b0; autoSdo = 4'h5;
    #1;
    check({csN, sclk, sdo} == {1'b1, 1'b0, 4'h5}, "R2 muxSel low", {csN, sclk, sdo}, 6'h25);
    muxSel = 1'b1; autoSdo = 4'h0;
    @(negedge clk);
  endtask

  task automatic t_ignored();
    clearMon();
    manEn = 1'b0;
    sendCmd(16'h28A5);
    check(busy == 1'b0, "R3 manEn low busy", busy, 0);
    manEn = 1'b1;
    idleCycles(20);
    check(riseCnt == 0, "R3 manEn low edges", riseCnt, 0);
    sendCmd(16'h08A5);
    check(busy == 1'b0, "R3 no write flag busy", busy, 0);
    idleCycles(20);
    check(riseCnt == 0, "R3 no write flag edges", riseCnt, 0);
    sendCmd(16'h2533);
    check(busy == 1'b0, "R11 unknown op busy", busy, 0);
    idleCycles(20);
    check(riseCnt == 0 && csN == 1'b1, "R11 unknown op pins", riseCnt, 0);
  endtask

  task automatic t_cs();
    clearMon();
    sendCmd(16'h2100); waitIdle();
    check(csN == 1'b0, "R4 cs low", csN, 0);
    sendCmd(16'h2000); waitIdle();
    check(csN == 1'b1, "R4 cs high", csN, 1);
    check(riseCnt == 0, "R4 no clock", riseCnt, 0);
  endtask

  task automatic t_clk();
    clearMon();
    sendCmd(16'h22FF); waitIdle();
    check(riseCnt == 1, "R5 pulse count", riseCnt, 1);
    check(riseSdo[0] == 4'h0, "R5 data zero", riseSdo[0], 0);
  endtask

  task automatic t_out1(input logic [7:0] b);
    logic [7:0] got;
    logic upper;
    clearMon();
    sendCmd({8'h28, b}); waitIdle();
    got = '0; upper = 1'b0;
    for (int i = 0; i < 8; i++) begin
      got = {got[6:0], riseSdo[i][0]};
      upper = upper | (|riseSdo[i][3:1]);
    end
    check(riseCnt == 8, "R6 edge count", riseCnt, 8);
    check(got == b, "R6 byte", got, b);
    check(upper == 1'b0, "R6 unused lines", upper, 0);
  endtask

  task automatic t_out2(input logic [7:0] b);
    logic [7:0] got;
    clearMon();
    sendCmd({8'h29, b}); waitIdle();
    got = '0;
    for (int i = 0; i < 4; i++) got = {got[5:0], riseSdo[i][1:0]};
    check(riseCnt == 4, "R7 edge count", riseCnt, 4);
    check(got == b, "R7 byte", got, b);
  endtask

  task automatic t_out4(input logic [7:0] b);
    logic [7:0] got;
    clearMon();
    sendCmd({8'h2A, b}); waitIdle();
    got = {riseSdo[0], riseSdo[1]};
    check(riseCnt == 2, "R8 edge count", riseCnt, 2);
    check(got == b, "R8 byte", got, b);
  endtask

  task automatic t_busy();
    int n;
    clearMon();
    sendCmd(16'h2855);
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    n = 1;
    while (busy && n < 500) begin
      @(negedge clk);
      if (busy) n++;
    end
    check(n == 1 + 16 * HALF, "R9 busy length", n, 1 + 16 * HALF);
    check(sclk == 1'b0, "R9 clock idle low", sclk, 0);
  endtask

  task automatic t_fifo();
    clearMon();
    sendCmd(16'h28FF);
    @(negedge clk);
    for (int i = 0; i < 5; i++) sendCmd(16'h2800 | 16'(i));
    waitIdle();
    check(riseCnt == 40, "R10 one write dropped when full", riseCnt, 40);
    check(riseSdo[39][0] == 1'b1, "R10 last kept byte", riseSdo[39], 1);
  endtask

  task automatic t_timing();
    clearMon();
    sendCmd(16'h28AA); waitIdle();
    check(hiTime == HALF * 10.0, "R12 high time", int'(hiTime), HALF * 10);
    check(period == 2 * HALF * 10.0, "R12 rise spacing", int'(period), 2 * HALF * 10);
  endtask

  task automatic t_resetSeq();
    clearMon();
    sendCmd(16'h2100); waitIdle();
    sendCmd(16'h2800); waitIdle();
    sendCmd(16'h2000); waitIdle();
    for (int i = 0; i < 4; i++) begin sendCmd(16'h2800); waitIdle(); end
    check(riseCnt == 40, "R13 total edges", riseCnt, 40);
    check(riseCsLow == 8, "R13 edges with cs low", riseCsLow, 8);
    check(csN == 1'b1, "R13 cs ends high", csN, 1);
  endtask

  initial begin
    idleCycles(3);
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_mux();
    t_ignored();
    t_cs();
    t_clk();
    t_out1(8'hA5); t_out1(8'h3C); t_out1(8'h81);
    t_out2(8'hC6); t_out2(8'h1B);
    t_out4(8'h7E); t_out4(8'hD2);
    t_busy();
    t_fifo();
    t_timing();
    t_resetSeq();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      check(0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule